// File: doc/BRIEF.md
# Supervisory Reset Pulse Generator

This block drives a pair of complementary system reset pins from a digitized supply-good flag. One pin is asserted high and the other is asserted low. Both pins behave as open-drain pads: the block only says when to pull each pin to its asserted level, and it reads back the level the pin actually shows. While the supply is below its trip point, reset is held. Once the supply recovers, reset stays asserted for a fixed number of slow reference ticks. With the default parameters this is 1000 ticks of a 5 kHz enable, about 200 ms.

Either pin can also be pulled to its asserted level from outside. The block watches both pins through synchronizers. An assertion edge that the block did not cause itself starts a full timeout. This lets the block clean up a push-button or a noisy external reset line as well as cover power-up. The timeout counter advances only on cycles where `tick` is high, so the block runs from a fast system clock.

Top module: `rst_supervisor`

## Requirements
- R1: When `supply_ok` is 0, `hi_pin_drv` and `lo_pin_drv` are both 1 in the same cycle, before any clock edge, through a combinational path.
- R2: `hi_pin_drv` and `lo_pin_drv` are always equal. On `hi_pin_drv`, 1 means pull the active-high pin to 1. On `lo_pin_drv`, 1 means pull the active-low pin to 0.
- R3: While `rst_n` is low, both drives are 1. After `rst_n` is released with the supply good, the drives stay 1 for the next TIMEOUT-1 tick cycles. They fall at the clock edge that samples the TIMEOUT-th tick.
- R4: After `supply_ok` returns to 1, reset is held for exactly TIMEOUT further ticks. Ticks counted in the same way as R3.
- R5: A 0-to-1 change on `hi_pin_lvl` that the block did not drive starts a full timeout. The drives rise at the third rising clock edge after the pin changes.
- R6: A 1-to-0 change on `lo_pin_lvl` that the block did not drive starts a full timeout, with the same three-edge latency as R5.
- R7: A 1-to-0 change on `hi_pin_lvl` or a 0-to-1 change on `lo_pin_lvl` never starts a timeout.
- R8: Pin edges caused by the block's own drive never start a timeout. A one-cycle supply dip therefore gives exactly one timeout of TIMEOUT ticks.
- R9: If a load (supply low or external edge) and a tick fall in the same cycle, the counter takes the full TIMEOUT value and the tick is not counted.
- R10: A supply dip at any point of a running timeout restarts it from the full TIMEOUT value.
- R11: Without ticks, an asserted reset is held indefinitely.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block's flops |
| tick | input | 1 | Clock enable of the slow reference, one cycle wide |
| supply_ok | input | 1 | Digitized comparator output, 1 = supply above trip point |
| hi_pin_lvl | input | 1 | Sensed level of the active-high reset pin |
| lo_pin_lvl | input | 1 | Sensed level of the active-low reset pin |
| hi_pin_drv | output | 1 | Drive enable pulling the active-high pin to 1 |
| lo_pin_drv | output | 1 | Drive enable pulling the active-low pin to 0 |

## Verification
Two functions can fall in the same cycle. A counter load, from a supply dip or an external edge, can coincide with a tick that would otherwise decrement the counter. The bench provokes this by dropping `supply_ok` in a tick cycle, both from idle and at every position of a running countdown. It then counts exactly TIMEOUT ticks before the release it expects. A design that counts that tick would release one tick early. A second pair is the block's own drive rising at the same time as its synchronized pins. Ticks are given on every cycle right after a dip, so a self-retrigger would show up as a late release.

// File: rtl/rstsup_pkg.sv
package rstsup_pkg;
    // Asserted level of a reset pin
    typedef enum logic {
        PIN_ACT_LOW  = 1'b0,
        PIN_ACT_HIGH = 1'b1
    } pin_pol_e;
endpackage

// File: rtl/rstsup_pin_edge.sv
module rstsup_pin_edge
    import rstsup_pkg::*;
#(
    parameter pin_pol_e POL         = PIN_ACT_HIGH,
    parameter int       SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_lvl,
    input  logic mask,
    output logic trig
);
    localparam logic IDLE_LVL = ~logic'(POL);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   last;
    } edge_st_t;

    edge_st_t st_d, st_q;
    logic     assert_edge;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[SYNC_STAGES-2:0], pin_lvl};
        st_d.last = st_q.sync[SYNC_STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sync <= {SYNC_STAGES{IDLE_LVL}};
            st_q.last <= IDLE_LVL;
        end else begin
            st_q <= st_d;
        end
    end

    generate
        if (POL == PIN_ACT_HIGH) begin : g_rise
            assign assert_edge = st_q.sync[SYNC_STAGES-1] & ~st_q.last;
        end else begin : g_fall
            assign assert_edge = ~st_q.sync[SYNC_STAGES-1] & st_q.last;
        end
    endgenerate

    assign trig = assert_edge & ~mask;

    // R5 R6: one pin change gives one trigger pulse
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> !trig);
endmodule

// File: rtl/rstsup_timer.sv
module rstsup_timer #(
    parameter int TIMEOUT = 1000,
    parameter int CW      = $clog2(TIMEOUT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic load,
    output logic busy
);
    localparam logic [CW-1:0] FULL = CW'(TIMEOUT);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_st_t;

    tmr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.cnt = FULL;
        end else if (tick && (st_q.cnt != '0)) begin
            st_d.cnt = st_q.cnt - CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= FULL;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = (st_q.cnt != '0);

    // R9
    load_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (st_q.cnt == FULL));

    // R11
    hold_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load) |=> $stable(st_q.cnt));

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= FULL);
endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor
    import rstsup_pkg::*;
#(
    parameter int TIMEOUT     = 1000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic supply_ok,
    input  logic hi_pin_lvl,
    input  logic lo_pin_lvl,
    output logic hi_pin_drv,
    output logic lo_pin_drv
);
    localparam int CW   = $clog2(TIMEOUT + 1);
    localparam int HIST = SYNC_STAGES + 1;

    typedef struct packed {
        logic [HIST-1:0] hist;
    } top_st_t;

    top_st_t st_d, st_q;
    logic    busy, drive, mask, load, trig_hi, trig_lo;

    assign drive = ~supply_ok | busy;
    assign mask  = drive | (|st_q.hist);
    assign load  = ~supply_ok | trig_hi | trig_lo;

    always_comb begin
        st_d      = st_q;
        st_d.hist = {st_q.hist[HIST-2:0], drive};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.hist <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    rstsup_pin_edge #(.POL(PIN_ACT_HIGH), .SYNC_STAGES(SYNC_STAGES)) u_edge_hi (
        .clk(clk), .rst_n(rst_n), .pin_lvl(hi_pin_lvl), .mask(mask), .trig(trig_hi)
    );

    rstsup_pin_edge #(.POL(PIN_ACT_LOW), .SYNC_STAGES(SYNC_STAGES)) u_edge_lo (
        .clk(clk), .rst_n(rst_n), .pin_lvl(lo_pin_lvl), .mask(mask), .trig(trig_lo)
    );

    rstsup_timer #(.TIMEOUT(TIMEOUT), .CW(CW)) u_timer (
        .clk(clk), .rst_n(rst_n), .tick(tick), .load(load), .busy(busy)
    );

    assign hi_pin_drv = drive;
    assign lo_pin_drv = drive;

    // R1
    supply_low_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |-> (hi_pin_drv && lo_pin_drv));

    // R2
    drv_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hi_pin_drv == lo_pin_drv);

    // R8
    no_self_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(hi_pin_drv) |-> !(trig_hi || trig_lo));

    // R5 R6
    ext_trig_asserts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_hi || trig_lo) |=> (hi_pin_drv && lo_pin_drv));
endmodule

// File: tb/rst_supervisor_bench.sv
module rst_supervisor_bench;
    localparam int CLK_PERIOD = 10;
    localparam int T          = 6;

    logic clk = 1'b0;
    logic rst_n, tick, supply_ok, ext_hi, ext_lo;
    logic hi_pin_drv, lo_pin_drv, hi_pin_lvl, lo_pin_lvl;
    int   checks = 0;
    int   fails  = 0;

    // open-drain pad model: pull-down on the high pin, pull-up on the low pin
    assign hi_pin_lvl = hi_pin_drv | ext_hi;
    assign lo_pin_lvl = ~(lo_pin_drv | ext_lo);

    always #(CLK_PERIOD/2) clk = ~clk;

    rst_supervisor #(.TIMEOUT(T), .SYNC_STAGES(2)) u_rst_supervisor (
        .clk(clk), .rst_n(rst_n), .tick(tick), .supply_ok(supply_ok),
        .hi_pin_lvl(hi_pin_lvl), .lo_pin_lvl(lo_pin_lvl),
        .hi_pin_drv(hi_pin_drv), .lo_pin_drv(lo_pin_drv)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic cyc(input logic tk);
        tick = tk;
        @(posedge clk);
        @(negedge clk);
        tick = 1'b0;
    endtask

    // expects the reset to be held for exactly T ticks given one per cycle
    task automatic window(input string req);
        for (int i = 1; i <= T; i++) begin
            cyc(1'b1);
            chk(req, hi_pin_drv, logic'(i < T));
            chk(req, lo_pin_drv, logic'(i < T));
        end
        for (int j = 0; j < 4; j++) begin
            cyc(1'b1);
            chk(req, hi_pin_drv, 1'b0);
        end
    endtask

    task automatic blip();
        supply_ok = 1'b0;
        #1;
        chk("R1", hi_pin_drv, 1'b1);
        chk("R1", lo_pin_drv, 1'b1);
        cyc(1'b0);
        supply_ok = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; tick = 1'b0; supply_ok = 1'b1; ext_hi = 1'b0; ext_lo = 1'b0;
        repeat (3) @(negedge clk);
        // R3 reset state
        chk("R3", hi_pin_drv, 1'b1);
        chk("R3", lo_pin_lvl, 1'b0);
        rst_n = 1'b1;
        window("R3");

        // R11: held without ticks, then R4 exact count
        supply_ok = 1'b0;
        #1;
        chk("R1", hi_pin_drv, 1'b1);
        repeat (3) cyc(1'b1);
        supply_ok = 1'b1;
        repeat (20) cyc(1'b0);
        chk("R11", hi_pin_drv, 1'b1);
        chk("R11", lo_pin_drv, 1'b1);
        window("R4");

        // R8: one-cycle dip, ticks every cycle right after
        blip();
        window("R8");

        // R9: dip in a tick cycle
        supply_ok = 1'b0;
        cyc(1'b1);
        supply_ok = 1'b1;
        window("R9");

        // R10: dip at each position of a running countdown
        for (int k = 0; k < T; k++) begin
            blip();
            repeat (k) cyc(1'b1);
            supply_ok = 1'b0;
            cyc(1'b1);
            supply_ok = 1'b1;
            window("R10");
        end

        // R5: external rise on the active-high pin
        ext_hi = 1'b1;
        cyc(1'b0);
        chk("R5", hi_pin_drv, 1'b0);
        cyc(1'b0);
        chk("R5", hi_pin_drv, 1'b0);
        cyc(1'b0);
        chk("R5", hi_pin_drv, 1'b1);
        window("R5");
        // R7: release of the high pin (falling) has no effect
        ext_hi = 1'b0;
        repeat (6) cyc(1'b0);
        chk("R7", hi_pin_drv, 1'b0);

        // R6: external fall on the active-low pin
        ext_lo = 1'b1;
        cyc(1'b0);
        chk("R6", lo_pin_drv, 1'b0);
        cyc(1'b0);
        chk("R6", lo_pin_drv, 1'b0);
        cyc(1'b0);
        chk("R6", lo_pin_drv, 1'b1);
        window("R6");
        // R7: release of the low pin (rising) has no effect
        ext_lo = 1'b0;
        repeat (6) cyc(1'b0);
        chk("R7", lo_pin_drv, 1'b0);
        chk("R2", hi_pin_drv, lo_pin_drv);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule